// File: doc/BRIEF.md
# Speculative Load/Store Ordering Unit

This unit decides, cycle by cycle, whether a load may go ahead while older stores still lack an address. Stores are entered in age order into a small buffer when they are allocated, and later receive their address and data when their address generation completes. A load presented to the unit is issued at once by default, even past stores whose address is still unknown. If an older store with a known, equal address exists, the load takes its data from the youngest such store.

Because early issue is a guess, every store address that resolves is compared against the loads that have already issued and are younger than that store. A match is a violation. It is reported one cycle later with the sequence number of the oldest offending load, so the surrounding pipeline can replay from there. The same event marks the offending load's PC in a one-bit-per-entry dependence table. A later load whose PC maps to a marked entry is held back while any older store address is unknown. The whole table is wiped on a fixed period, so stale marks do not hold loads back for ever.

Age is carried by a 6-bit sequence number on every memory operation. Operation a is older than b when (a - b) modulo 64 has its top bit set, which keeps the comparison valid across wraparound while fewer than 32 operations are in flight.

Top module: `lsd_top`

## Requirements
- R1: After synchronous reset the buffers are empty, `viol_valid` is 0, the dependence table is clear, and any valid load is issued with `ld_fwd_hit` = 0.
- R2: A load whose table entry is unmarked is issued in the same cycle it is presented (`ld_issue` = 1), even when older stores have unknown addresses.
- R3: When one or more older stores have a known address equal to the load address, `ld_fwd_hit` is 1 and `ld_fwd_data` is the data of the youngest of those stores, in the same cycle.
- R4: A load gets `ld_fwd_hit` = 0 when no older store with a known address has an equal address; stores equal in address but younger than the load, or not yet resolved, do not forward.
- R5: A store address resolution whose address equals that of an issued, younger load sets `viol_valid` to 1 for exactly the following cycle. Resolutions that match only older loads, or no loads, leave `viol_valid` at 0.
- R6: When several issued younger loads match one store resolution, `viol_seq` reports the oldest of them.
- R7: A load issued in the same cycle as a store resolution is included in that resolution's violation check.
- R8: A violation marks the table entry selected by the offending load's `ld_pc`. From the next cycle, a load with that `ld_pc` has `ld_issue` = 0 while any older store has an unknown address. It issues once those addresses are known, and stores younger than the load never hold it back. Other PCs are unaffected.
- R9: The dependence table is cleared every `CLEAR_PERIOD` (4096) cycles, counted from the end of reset.
- R10: Age comparisons wrap modulo 64: sequence 62 is older than 1, and sequence 63 is older than 2.
- R11: Retiring a store removes the oldest buffered store, which no longer forwards data to loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_alloc_valid | input | 1 | Enter a new store, address unknown, at the young end of the buffer |
| st_alloc_seq | input | 6 | Sequence number of the allocated store |
| st_res_valid | input | 1 | A buffered store's address and data are now known |
| st_res_seq | input | 6 | Sequence number of the resolving store |
| st_res_addr | input | 16 | Address of the resolving store |
| st_res_data | input | 32 | Data of the resolving store |
| st_retire_valid | input | 1 | Remove the oldest buffered store |
| ld_valid | input | 1 | A load asks to issue this cycle |
| ld_seq | input | 6 | Sequence number of the load |
| ld_pc | input | 6 | Low PC bits of the load, dependence table index |
| ld_addr | input | 16 | Address of the load |
| ld_retire_valid | input | 1 | Remove the oldest issued load from tracking |
| ld_issue | output | 1 | The load is issued this cycle |
| ld_fwd_hit | output | 1 | Load data comes from a buffered store |
| ld_fwd_data | output | 32 | Forwarded store data |
| viol_valid | output | 1 | A violation was found on the previous cycle's store resolution |
| viol_seq | output | 6 | Sequence number of the oldest violating load |

## Verification
Issue and forwarding are combinational. The bench drives a load one time unit after a rising edge and compares `ld_issue`, `ld_fwd_hit` and `ld_fwd_data` before the next edge. A violation appears on the edge that samples the store resolution, so `viol_valid` and `viol_seq` are read one time unit after that edge and again one cycle later to confirm the one-cycle pulse. A dependence mark takes effect on that same edge, so the held-back load is presented on the cycle right after the violation. The periodic clear is checked by presenting a marked load more than 4096 cycles after reset.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
    localparam int SEQ_W  = 6;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic  valid;
        seq_t  seq;
        logic  addr_ok;
        addr_t addr;
        data_t data;
    } st_ent_t;

    // a is older than b when the modular difference is negative
    function automatic logic seq_older(input seq_t a, input seq_t b);
        seq_t d;
        d = a - b;
        return d[SEQ_W-1];
    endfunction
endpackage

// File: rtl/lsd_store_buf.sv
module lsd_store_buf
    import lsd_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc_v,
    input  seq_t  alloc_seq,
    input  logic  res_v,
    input  seq_t  res_seq,
    input  addr_t res_addr,
    input  data_t res_data,
    input  logic  ret_v,
    input  seq_t  q_seq,
    input  addr_t q_addr,
    output logic  older_unk,
    output logic  fwd_hit,
    output data_t fwd_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

    st_ent_t       ent_q [DEPTH];
    logic [PW-1:0] head_q, tail_q;
    logic [PW:0]   cnt_q;
    logic          do_alloc, do_ret;

    assign do_alloc = alloc_v && (cnt_q != FULL);
    assign do_ret   = ret_v && (cnt_q != '0);

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (res_v && ent_q[i].valid && ent_q[i].seq == res_seq) begin
                    ent_q[i].addr_ok <= 1'b1;
                    ent_q[i].addr    <= res_addr;
                    ent_q[i].data    <= res_data;
                end
            end
            if (do_alloc) begin
                ent_q[tail_q] <= '{valid: 1'b1, seq: alloc_seq, addr_ok: 1'b0,
                                   addr: '0, data: '0};
                tail_q <= nxt(tail_q);
            end
            if (do_ret) begin
                ent_q[head_q].valid <= 1'b0;
                head_q <= nxt(head_q);
            end
            case ({do_alloc, do_ret})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Search older stores: any unknown address, and youngest matching one
    always_comb begin
        seq_t best_seq;
        older_unk = 1'b0;
        fwd_hit   = 1'b0;
        fwd_data  = '0;
        best_seq  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_q[i].valid && seq_older(ent_q[i].seq, q_seq)) begin
                if (!ent_q[i].addr_ok) begin
                    older_unk = 1'b1;
                end else if (ent_q[i].addr == q_addr &&
                             (!fwd_hit || seq_older(best_seq, ent_q[i].seq))) begin
                    fwd_hit  = 1'b1;
                    best_seq = ent_q[i].seq;
                    fwd_data = ent_q[i].data;
                end
            end
        end
    end
endmodule

// File: rtl/lsd_load_tab.sv
module lsd_load_tab
    import lsd_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_v,
    input  seq_t          wr_seq,
    input  addr_t         wr_addr,
    input  logic [IW-1:0] wr_pc,
    input  logic          ret_v,
    input  logic          chk_v,
    input  seq_t          chk_seq,
    input  addr_t         chk_addr,
    output logic          hit,
    output seq_t          hit_seq,
    output logic [IW-1:0] hit_pc
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

    typedef struct packed {
        logic          valid;
        seq_t          seq;
        addr_t         addr;
        logic [IW-1:0] pc;
    } ld_ent_t;

    ld_ent_t       ent_q [DEPTH];
    logic [PW-1:0] head_q, tail_q;
    logic [PW:0]   cnt_q;
    logic          do_wr, do_ret;

    assign do_wr  = wr_v && (cnt_q != FULL);
    assign do_ret = ret_v && (cnt_q != '0);

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_wr) begin
                ent_q[tail_q] <= '{valid: 1'b1, seq: wr_seq, addr: wr_addr, pc: wr_pc};
                tail_q <= nxt(tail_q);
            end
            if (do_ret) begin
                ent_q[head_q].valid <= 1'b0;
                head_q <= nxt(head_q);
            end
            case ({do_wr, do_ret})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Oldest issued load younger than the resolving store with equal address;
    // the load being issued this very cycle takes part as well
    always_comb begin
        hit     = 1'b0;
        hit_seq = '0;
        hit_pc  = '0;
        if (chk_v) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ent_q[i].valid && ent_q[i].addr == chk_addr &&
                    seq_older(chk_seq, ent_q[i].seq) &&
                    (!hit || seq_older(ent_q[i].seq, hit_seq))) begin
                    hit     = 1'b1;
                    hit_seq = ent_q[i].seq;
                    hit_pc  = ent_q[i].pc;
                end
            end
            if (wr_v && wr_addr == chk_addr && seq_older(chk_seq, wr_seq) &&
                (!hit || seq_older(wr_seq, hit_seq))) begin
                hit     = 1'b1;
                hit_seq = wr_seq;
                hit_pc  = wr_pc;
            end
        end
    end
endmodule

// File: rtl/lsd_dep_pred.sv
module lsd_dep_pred #(
    parameter int ENTRIES = 64,
    parameter int PERIOD  = 4096
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    input  logic                       train_v,
    input  logic [$clog2(ENTRIES)-1:0] train_idx,
    output logic                       rd_flag,
    output logic                       any_flag
);
    localparam int CW = $clog2(PERIOD);

    logic [ENTRIES-1:0] flag_q;
    logic [CW-1:0]      tmr_q;
    logic               wipe;

    assign wipe = (tmr_q == CW'(PERIOD-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            tmr_q  <= '0;
        end else begin
            tmr_q <= wipe ? '0 : tmr_q + 1'b1;
            if (wipe) flag_q <= '0;
            // a mark trained on the wipe cycle survives it
            if (train_v) flag_q[train_idx] <= 1'b1;
        end
    end

    assign rd_flag  = flag_q[rd_idx];
    assign any_flag = |flag_q;
endmodule

// File: rtl/lsd_top.sv
module lsd_top
    import lsd_pkg::*;
#(
    parameter  int SB_DEPTH     = 8,
    parameter  int LT_DEPTH     = 8,
    parameter  int PRED_ENTRIES = 64,
    parameter  int CLEAR_PERIOD = 4096,
    localparam int PIDX_W       = $clog2(PRED_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_alloc_valid,
    input  logic [SEQ_W-1:0]  st_alloc_seq,
    input  logic              st_res_valid,
    input  logic [SEQ_W-1:0]  st_res_seq,
    input  logic [ADDR_W-1:0] st_res_addr,
    input  logic [DATA_W-1:0] st_res_data,
    input  logic              st_retire_valid,
    input  logic              ld_valid,
    input  logic [SEQ_W-1:0]  ld_seq,
    input  logic [PIDX_W-1:0] ld_pc,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_retire_valid,
    output logic              ld_issue,
    output logic              ld_fwd_hit,
    output logic [DATA_W-1:0] ld_fwd_data,
    output logic              viol_valid,
    output logic [SEQ_W-1:0]  viol_seq
);
    logic              sb_older_unk, sb_hit;
    data_t             sb_data;
    logic              lt_hit;
    seq_t              lt_seq;
    logic [PIDX_W-1:0] lt_pc;
    logic              pred_flag, pred_any;
    logic              viol_q;
    seq_t              viol_seq_q;

    lsd_store_buf #(.DEPTH(SB_DEPTH)) u_sb (
        .clk(clk), .rst(rst),
        .alloc_v(st_alloc_valid), .alloc_seq(st_alloc_seq),
        .res_v(st_res_valid), .res_seq(st_res_seq),
        .res_addr(st_res_addr), .res_data(st_res_data),
        .ret_v(st_retire_valid),
        .q_seq(ld_seq), .q_addr(ld_addr),
        .older_unk(sb_older_unk), .fwd_hit(sb_hit), .fwd_data(sb_data)
    );

    lsd_dep_pred #(.ENTRIES(PRED_ENTRIES), .PERIOD(CLEAR_PERIOD)) u_pred (
        .clk(clk), .rst(rst),
        .rd_idx(ld_pc), .train_v(lt_hit), .train_idx(lt_pc),
        .rd_flag(pred_flag), .any_flag(pred_any)
    );

    // speculate by default; marked loads wait for older store addresses
    assign ld_issue    = ld_valid && !(pred_flag && sb_older_unk);
    assign ld_fwd_hit  = ld_valid && sb_hit;
    assign ld_fwd_data = ld_fwd_hit ? sb_data : '0;

    lsd_load_tab #(.DEPTH(LT_DEPTH), .IW(PIDX_W)) u_lt (
        .clk(clk), .rst(rst),
        .wr_v(ld_issue), .wr_seq(ld_seq), .wr_addr(ld_addr), .wr_pc(ld_pc),
        .ret_v(ld_retire_valid),
        .chk_v(st_res_valid), .chk_seq(st_res_seq), .chk_addr(st_res_addr),
        .hit(lt_hit), .hit_seq(lt_seq), .hit_pc(lt_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_q     <= 1'b0;
            viol_seq_q <= '0;
        end else begin
            viol_q     <= lt_hit;
            viol_seq_q <= lt_hit ? lt_seq : viol_seq_q;
        end
    end

    assign viol_valid = viol_q;
    assign viol_seq   = viol_seq_q;
endmodule

// File: rtl/lsd_checker.sv
module lsd_checker (
    input logic clk,
    input logic rst,
    input logic ld_valid,
    input logic ld_issue,
    input logic ld_fwd_hit,
    input logic st_res_valid,
    input logic viol_valid,
    input logic older_unk,
    input logic any_flag
);
    // R1: no violation is reported on the first cycle out of reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !viol_valid);

    // R2, R8: a load is held back only when an older store address is unknown
    assert_hold_needs_unknown_R8: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_issue) |-> older_unk);

    // R3: forwarding only for a presented load
    assert_fwd_needs_load_R3: assert property (@(posedge clk) disable iff (rst)
        ld_fwd_hit |-> ld_valid);

    // R5: every violation follows a store address resolution
    assert_viol_after_resolve_R5: assert property (@(posedge clk) disable iff (rst)
        viol_valid |-> $past(st_res_valid));

    // R8: a violation leaves at least one mark in the dependence table
    assert_viol_trains_R8: assert property (@(posedge clk) disable iff (rst)
        viol_valid |-> any_flag);

    // R2: with an empty table every presented load issues
    assert_issue_unmarked_R2: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !any_flag) |-> ld_issue);
endmodule

bind lsd_top lsd_checker u_chk (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_issue(ld_issue), .ld_fwd_hit(ld_fwd_hit),
    .st_res_valid(st_res_valid), .viol_valid(viol_valid),
    .older_unk(sb_older_unk), .any_flag(pred_any)
);

// File: tb/tb_lsd_top.sv
`timescale 1ns/1ps
module tb_lsd_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_alloc_valid, st_res_valid, st_retire_valid;
    logic [5:0]  st_alloc_seq, st_res_seq, ld_seq, ld_pc, viol_seq;
    logic [15:0] st_res_addr, ld_addr;
    logic [31:0] st_res_data, ld_fwd_data;
    logic        ld_valid, ld_retire_valid, ld_issue, ld_fwd_hit, viol_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lsd_top dut (.*);

    typedef struct packed {
        logic [5:0]  seq;
        logic [15:0] addr;
        logic        hit;
        logic [31:0] data;
    } vec_t;

    // stores: 10 @0x40 A, 11 unknown, 12 @0x40 B, 13 @0x80 C
    localparam vec_t VEC [6] = '{
        '{6'd14, 16'h0040, 1'b1, 32'hBBBB_0002},
        '{6'd11, 16'h0040, 1'b1, 32'hAAAA_0001},
        '{6'd9,  16'h0040, 1'b0, 32'h0},
        '{6'd14, 16'h0080, 1'b1, 32'hCCCC_0003},
        '{6'd13, 16'h0080, 1'b0, 32'h0},
        '{6'd14, 16'h0044, 1'b0, 32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        st_alloc_valid = 0; st_alloc_seq = '0;
        st_res_valid = 0; st_res_seq = '0; st_res_addr = '0; st_res_data = '0;
        st_retire_valid = 0;
        ld_valid = 0; ld_seq = '0; ld_pc = '0; ld_addr = '0; ld_retire_valid = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        idle(); rst = 1; tick(); tick(); rst = 0;
    endtask

    task automatic alloc(input logic [5:0] s);
        st_alloc_valid = 1; st_alloc_seq = s; tick(); idle();
    endtask

    task automatic resolve(input logic [5:0] s, input logic [15:0] a, input logic [31:0] d);
        st_res_valid = 1; st_res_seq = s; st_res_addr = a; st_res_data = d; tick(); idle();
    endtask

    task automatic present(input logic [5:0] s, input logic [5:0] pc, input logic [15:0] a);
        ld_valid = 1; ld_seq = s; ld_pc = pc; ld_addr = a; #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        idle();
        do_reset();
        // R1: reset state
        chk("R1 viol_valid", viol_valid, 0);
        alloc(6'd3);
        present(6'd4, 6'd1, 16'h10);
        chk("R1 issue", ld_issue, 1);
        chk("R1 fwd_hit", ld_fwd_hit, 0);
        tick(); idle();

        // R3/R4 vector walk
        do_reset();
        alloc(6'd10); alloc(6'd11); alloc(6'd12); alloc(6'd13);
        resolve(6'd10, 16'h40, 32'hAAAA_0001);
        resolve(6'd12, 16'h40, 32'hBBBB_0002);
        resolve(6'd13, 16'h80, 32'hCCCC_0003);
        foreach (VEC[i]) begin
            present(VEC[i].seq, 6'd0, VEC[i].addr);
            chk("R2 issue past unknown", ld_issue, 1);
            chk(VEC[i].hit ? "R3 fwd_hit" : "R4 fwd_hit", ld_fwd_hit, VEC[i].hit);
            chk(VEC[i].hit ? "R3 fwd_data" : "R4 fwd_data", ld_fwd_data, VEC[i].data);
            tick(); idle();
        end
        // R11: retire store 10
        st_retire_valid = 1; tick(); idle();
        present(6'd11, 6'd0, 16'h40);
        chk("R11 retired store no fwd", ld_fwd_hit, 0);
        tick(); idle();
        present(6'd14, 6'd0, 16'h40);
        chk("R11 remaining fwd", ld_fwd_data, 32'hBBBB_0002);
        tick(); idle();

        // R5/R6/R8 violation and training
        do_reset();
        alloc(6'd20); alloc(6'd30);
        present(6'd25, 6'd3, 16'h100); tick(); idle();
        present(6'd27, 6'd5, 16'h100); tick(); idle();
        present(6'd22, 6'd7, 16'h200); tick(); idle();
        present(6'd35, 6'd9, 16'h100); tick(); idle();
        chk("R5 no viol before resolve", viol_valid, 0);
        resolve(6'd20, 16'h100, 32'h1);
        chk("R5 viol_valid", viol_valid, 1);
        chk("R6 oldest seq", viol_seq, 6'd25);
        tick();
        chk("R5 one-cycle pulse", viol_valid, 0);
        resolve(6'd30, 16'h300, 32'h2);
        chk("R5 no match no viol", viol_valid, 0);
        alloc(6'd38);
        present(6'd40, 6'd3, 16'h400);
        chk("R8 marked load waits", ld_issue, 0);
        tick(); idle();
        present(6'd41, 6'd5, 16'h500);
        chk("R8 unmarked pc issues", ld_issue, 1);
        tick(); idle();
        present(6'd37, 6'd3, 16'h600);
        chk("R8 younger unknown store ignored", ld_issue, 1);
        tick(); idle();
        resolve(6'd38, 16'h999, 32'h3);
        chk("R5 older-only loads no viol", viol_valid, 0);
        present(6'd40, 6'd3, 16'h400);
        chk("R8 issues once addresses known", ld_issue, 1);
        tick(); idle();
        // R9: periodic clear
        repeat (4100) tick();
        alloc(6'd50);
        present(6'd55, 6'd3, 16'h700);
        chk("R9 table cleared", ld_issue, 1);
        tick(); idle();

        // R7: same-cycle load and resolution
        do_reset();
        alloc(6'd5);
        st_res_valid = 1; st_res_seq = 6'd5; st_res_addr = 16'h10; st_res_data = 32'h9;
        present(6'd6, 6'd2, 16'h10);
        chk("R7 issue", ld_issue, 1);
        chk("R7 no fwd yet", ld_fwd_hit, 0);
        tick(); idle();
        chk("R7 viol_valid", viol_valid, 1);
        chk("R7 viol_seq", viol_seq, 6'd6);

        // R10: wraparound
        do_reset();
        alloc(6'd62);
        resolve(6'd62, 16'h20, 32'hD00D);
        present(6'd1, 6'd0, 16'h20);
        chk("R10 wrap fwd_hit", ld_fwd_hit, 1);
        chk("R10 wrap fwd_data", ld_fwd_data, 32'hD00D);
        tick(); idle();
        present(6'd60, 6'd0, 16'h20);
        chk("R10 older load no fwd", ld_fwd_hit, 0);
        tick(); idle();
        alloc(6'd63);
        present(6'd2, 6'd4, 16'h30); tick(); idle();
        resolve(6'd63, 16'h30, 32'h1);
        chk("R10 wrap viol_valid", viol_valid, 1);
        chk("R10 wrap viol_seq", viol_seq, 6'd2);

        done = 1;
        finish_run();
    end
endmodule